// File: doc/BRIEF.md
# Signed and Fractional 8x8 Multiply Unit

This unit multiplies two 8-bit operands and returns a 16-bit product. The product is split into a high byte and a low byte, ready to be written to a fixed pair of destination registers. A two-bit sign select chooses how the operands are read:

- both unsigned;
- both two's complement;
- first operand two's complement and second operand unsigned.

A separate fractional bit shifts the product left by one place. This suits Q-format (fixed-point fraction) arithmetic, where a product of two numbers with one integer bit needs re-aligning.

Each operation is launched by a one-cycle start strobe. Operands, sign select and fractional bit are captured on the clock edge that samples start high. The result and a one-cycle done pulse appear after the next edge. Only two flags are produced. The zero flag describes the final 16-bit result. The carry flag is bit 15 of the product before any fractional shift. The result and flags stay unchanged between completions. A new start may be issued on every cycle, so operations can stream through back to back.

Top module: `fxmul_unit`

## Requirements
- R1: With sign select 2'b00 and fractional bit low, {prod_hi, prod_lo} equals the unsigned product of opa and opb.
- R2: With sign select 2'b01, both operands are read as two's complement, and the result is the low 16 bits of their signed product.
- R3: With sign select 2'b10, opa is read as two's complement and opb as unsigned. Sign select 2'b11 behaves exactly as 2'b00.
- R4: With the fractional bit high, the result is the selected product shifted left by one bit, keeping the low 16 bits, with bit 0 equal to 0.
- R5: flag_c equals bit 15 of the 16-bit product taken before the fractional shift.
- R6: flag_z is 1 exactly when the final 16-bit result (after any shift) is zero.
- R7: A start sampled high on clock edge k gives done high for exactly the one cycle that follows edge k+1. A start may be accepted on every cycle, including a cycle in which done is high.
- R8: While done is low, prod_hi, prod_lo, flag_z and flag_c keep their last values, whatever opa, opb, sign select and fractional bit do.
- R9: Synchronous reset clears done, the result and both flags, and discards an operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch strobe |
| sign_mode | input | 2 | 00 unsigned x unsigned, 01 signed x signed, 10 signed x unsigned, 11 as 00 |
| frac | input | 1 | 1 selects the fractional product (shift left by one) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | 8 | Upper byte of the result |
| prod_lo | output | 8 | Lower byte of the result |
| flag_z | output | 1 | Zero flag of the final result |
| flag_c | output | 1 | Bit 15 of the product before the fractional shift |

## Verification
The case that needs care is a start that coincides with the done pulse of the previous operation, where launch and completion share a cycle. The bench provokes this by streaming a new start on every cycle through long sweeps. The sweeps cover every sign select and both fractional settings, all 256 values of opa against a set of edge-case opb values, and a full 65536-pair sweep of the mixed-sign fractional mode. Each done is matched against the expected result of the start issued exactly two samples earlier, and the idle gaps between bursts confirm that the outputs hold. A second coincidence, reset falling on an operation in flight, is provoked once and judged by done staying low and the outputs staying cleared.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;

    localparam int MUL_W  = 8;
    localparam int PROD_W = 2 * MUL_W;
    localparam int EXT_W  = MUL_W + 1;
    localparam int FULL_W = 2 * EXT_W;

    typedef enum logic [1:0] {
        SM_UU  = 2'b00,
        SM_SS  = 2'b01,
        SM_SU  = 2'b10,
        SM_RSV = 2'b11
    } sign_mode_e;

    typedef struct packed {
        logic [MUL_W-1:0] a;
        logic [MUL_W-1:0] b;
        sign_mode_e       mode;
        logic             frac;
    } mul_req_t;

    typedef struct packed {
        logic [PROD_W-1:0] value;
        logic              zero;
        logic              carry;
    } mul_res_t;

    function automatic logic a_is_signed(sign_mode_e m);
        return (m == SM_SS) || (m == SM_SU);
    endfunction

    function automatic logic b_is_signed(sign_mode_e m);
        return (m == SM_SS);
    endfunction

    function automatic logic [EXT_W-1:0] widen(logic [MUL_W-1:0] v, logic sgn);
        return {sgn & v[MUL_W-1], v};
    endfunction

endpackage

// File: rtl/fxmul_capture.sv
module fxmul_capture
    import fxmul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  mul_req_t req_in,
    output mul_req_t req_q,
    output logic     valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            req_q   <= '0;
        end else begin
            valid_q <= start;
            if (start) begin
                req_q <= req_in;
            end
        end
    end

endmodule

// File: rtl/fxmul_core.sv
module fxmul_core
    import fxmul_pkg::*;
(
    input  mul_req_t req,
    output mul_res_t res
);

    logic signed [EXT_W-1:0]  ext_a;
    logic signed [EXT_W-1:0]  ext_b;
    logic signed [FULL_W-1:0] full;
    logic        [PROD_W-1:0] raw;
    logic        [PROD_W-1:0] shaped;

    always_comb begin
        ext_a  = widen(req.a, a_is_signed(req.mode));
        ext_b  = widen(req.b, b_is_signed(req.mode));
        full   = ext_a * ext_b;
        raw    = full[PROD_W-1:0];
        shaped = req.frac ? {raw[PROD_W-2:0], 1'b0} : raw;
        res.value = shaped;
        res.zero  = (shaped == '0);
        res.carry = raw[PROD_W-1];
    end

endmodule

// File: rtl/fxmul_result.sv
module fxmul_result
    import fxmul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  mul_res_t res_in,
    output mul_res_t res_q,
    output logic     done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= load;
            if (load) begin
                res_q <= res_in;
            end
        end
    end

endmodule

// File: rtl/fxmul_unit.sv
module fxmul_unit
    import fxmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        sign_mode,
    input  logic              frac,
    input  logic [MUL_W-1:0]  opa,
    input  logic [MUL_W-1:0]  opb,
    output logic              done,
    output logic [MUL_W-1:0]  prod_hi,
    output logic [MUL_W-1:0]  prod_lo,
    output logic              flag_z,
    output logic              flag_c
);

    mul_req_t req_in;
    mul_req_t req_q;
    logic     req_valid;
    mul_res_t core_res;
    mul_res_t held_res;

    always_comb begin
        req_in.a    = opa;
        req_in.b    = opb;
        req_in.mode = sign_mode_e'(sign_mode);
        req_in.frac = frac;
    end

    fxmul_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req_in  (req_in),
        .req_q   (req_q),
        .valid_q (req_valid)
    );

    fxmul_core u_core (
        .req (req_q),
        .res (core_res)
    );

    fxmul_result u_result (
        .clk    (clk),
        .rst    (rst),
        .load   (req_valid),
        .res_in (core_res),
        .res_q  (held_res),
        .done_q (done)
    );

    assign prod_hi = held_res.value[PROD_W-1:MUL_W];
    assign prod_lo = held_res.value[MUL_W-1:0];
    assign flag_z  = held_res.zero;
    assign flag_c  = held_res.carry;

endmodule

// File: rtl/fxmul_unit_chk.sv
module fxmul_unit_chk
    import fxmul_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [1:0]       sign_mode,
    input logic             frac,
    input logic [MUL_W-1:0] opa,
    input logic [MUL_W-1:0] opb,
    input logic             done,
    input logic [MUL_W-1:0] prod_hi,
    input logic [MUL_W-1:0] prod_lo,
    input logic             flag_z,
    input logic             flag_c
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r7_done_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (done == $past(start, 2)));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !done) |-> $stable({prod_hi, prod_lo, flag_z, flag_c}));

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && {prod_hi, prod_lo, flag_z, flag_c} == '0));

    a_r1_unsigned_product: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && done && $past(sign_mode, 2) == 2'b00 && !$past(frac, 2))
        |-> ({prod_hi, prod_lo} == ({{MUL_W{1'b0}}, $past(opa, 2)} * {{MUL_W{1'b0}}, $past(opb, 2)})));

    a_r4_frac_lsb: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && done && $past(frac, 2)) |-> (prod_lo[0] == 1'b0));

    a_r5_carry_msb: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && done && !$past(frac, 2)) |-> (flag_c == prod_hi[MUL_W-1]));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_z == ({prod_hi, prod_lo} == '0)));

endmodule

bind fxmul_unit fxmul_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sign_mode (sign_mode),
    .frac      (frac),
    .opa       (opa),
    .opb       (opb),
    .done      (done),
    .prod_hi   (prod_hi),
    .prod_lo   (prod_lo),
    .flag_z    (flag_z),
    .flag_c    (flag_c)
);

// File: tb/fxmul_unit_test.sv
`timescale 1ns/1ps
module fxmul_unit_test;

    logic       clk;
    logic       rst;
    logic       start;
    logic [1:0] sign_mode;
    logic       frac;
    logic [7:0] opa;
    logic [7:0] opb;
    logic       done;
    logic [7:0] prod_hi;
    logic [7:0] prod_lo;
    logic       flag_z;
    logic       flag_c;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit run    = 0;

    logic        exp_v [4];
    logic [15:0] exp_p [4];
    logic        exp_z [4];
    logic        exp_c [4];
    logic [1:0]  exp_m [4];
    logic        exp_f [4];

    logic [15:0] held_p;
    logic        held_z;
    logic        held_c;

    fxmul_unit uut (
        .clk(clk), .rst(rst), .start(start), .sign_mode(sign_mode), .frac(frac),
        .opa(opa), .opb(opb), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic string prod_tag(input logic [1:0] m, input logic f);
        if (f)          return "R4";
        if (m == 2'b01) return "R2";
        if (m == 2'b10) return "R3";
        if (m == 2'b11) return "R3";
        return "R1";
    endfunction

    // Drive one cycle at the falling edge and record what the result must be.
    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [1:0] m,
                         input logic f, input logic st);
        int sa;
        int sb;
        int p;
        logic [15:0] raw;
        logic [15:0] res;
        int slot;
        @(negedge clk);
        opa = a; opb = b; sign_mode = m; frac = f; start = st;
        sa = ((m == 2'b01 || m == 2'b10) && a[7]) ? int'(a) - 256 : int'(a);
        sb = ((m == 2'b01) && b[7]) ? int'(b) - 256 : int'(b);
        p = sa * sb;
        raw = p[15:0];
        res = f ? {raw[14:0], 1'b0} : raw;
        slot = cyc & 3;
        exp_v[slot] = st;
        exp_p[slot] = res;
        exp_z[slot] = (res == 16'h0);
        exp_c[slot] = raw[15];
        exp_m[slot] = m;
        exp_f[slot] = f;
    endtask

    // Compare the outputs against the start issued two samples earlier.
    always @(negedge clk) begin
        if (run && !rst) begin
            int idx;
            idx = (cyc - 2) & 3;
            if (exp_v[idx]) begin
                chk(done === 1'b1, "R7 done after start", {31'b0, done}, 32'd1);
                chk({prod_hi, prod_lo} === exp_p[idx], prod_tag(exp_m[idx], exp_f[idx]),
                    {16'b0, prod_hi, prod_lo}, {16'b0, exp_p[idx]});
                chk(flag_c === exp_c[idx], "R5 carry", {31'b0, flag_c}, {31'b0, exp_c[idx]});
                chk(flag_z === exp_z[idx], "R6 zero", {31'b0, flag_z}, {31'b0, exp_z[idx]});
                held_p = exp_p[idx];
                held_z = exp_z[idx];
                held_c = exp_c[idx];
            end else begin
                chk(done === 1'b0, "R7 no done", {31'b0, done}, 32'd0);
                chk({prod_hi, prod_lo, flag_z, flag_c} === {held_p, held_z, held_c}, "R8 hold",
                    {14'b0, prod_hi, prod_lo, flag_z, flag_c}, {14'b0, held_p, held_z, held_c});
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [7:0] bvals [16];

    initial begin
        bvals = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF,
                  8'h40, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'h10};
        for (int i = 0; i < 4; i++) begin
            exp_v[i] = 1'b0; exp_p[i] = '0; exp_z[i] = 1'b0; exp_c[i] = 1'b0;
            exp_m[i] = '0; exp_f[i] = 1'b0;
        end
        held_p = '0; held_z = 1'b0; held_c = 1'b0;
        rst = 1'b1; start = 1'b0; sign_mode = '0; frac = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        // R9: outputs cleared while reset is held
        chk({done, prod_hi, prod_lo, flag_z, flag_c} === 19'h0, "R9 reset state",
            {13'b0, done, prod_hi, prod_lo, flag_z, flag_c}, 32'd0);

        // R9: reset lands on an operation in flight
        @(negedge clk);
        rst = 1'b0;
        drive(8'hFF, 8'hFF, 2'b00, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        @(negedge clk);
        chk({done, prod_hi, prod_lo, flag_z, flag_c} === 19'h0, "R9 in-flight discard",
            {13'b0, done, prod_hi, prod_lo, flag_z, flag_c}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_v[i] = 1'b0;
        run = 1'b1;
        drive(8'h00, 8'h00, 2'b00, 1'b0, 1'b0);
        drive(8'h00, 8'h00, 2'b00, 1'b0, 1'b0);

        // Streaming sweeps, one start per cycle (R1..R7), idle gaps test R8
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int j = 0; j < 16; j++)
                        drive(8'(a), bvals[j], 2'(m), 1'(f), 1'b1);
                    drive(8'(a) ^ 8'h5A, 8'hC3, 2'(m + 1), ~1'(f), 1'b0);
                    drive(8'hFF, 8'(a), 2'b01, 1'b1, 1'b0);
                end
            end
        end

        // Full pair sweep of the mixed-sign fractional mode (R3, R4, R5, R6)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++)
                drive(8'(a), 8'(b), 2'b10, 1'b1, 1'b1);
            drive(8'h80, 8'h80, 2'b01, 1'b0, 1'b0);
        end

        repeat (4) drive(8'h12, 8'h34, 2'b00, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule